// File: doc/BRIEF.md
# Instruction Extension Field Parser

This block sits behind the opcode decoder of a variable-length instruction pipeline. It walks the bytes that follow the fixed part of an instruction. The decoder hands over a descriptor with a single `start` pulse. The descriptor holds the two 5-bit operand addressing modes, the operand size that the opcode implies for immediates, the length of the fixed part, and how many implied trailing displacements the instruction carries.

From then on the parser takes extension bytes over a valid/ready handshake, strictly in stream order:

- index bytes for operand A and then operand B;
- the displacement or immediate fields of operand A, then those of operand B;
- the implied displacements.

A displacement encodes its own length in the top bits of its first byte, and the parser sign-extends it to 32 bits. An immediate takes its length from the descriptor. All multi-byte fields arrive most-significant byte first.

When the last field has been taken, the parser presents every extracted value together with the total instruction length. It holds them under `out_valid` until the consumer accepts them with `out_ready`, and then returns to idle.

Top module: `ext_parser`

## Requirements
- R1: After synchronous reset, `in_ready` and `out_valid` are 0 and the parser waits for `start`.
- R2: The parser latches the descriptor only when `start` arrives while it is idle. A `start` pulse, or a change of any descriptor input, during a parse or while results are presented has no effect on the results.
- R3: Operand mode codes 28, 29, 30 and 31 select scaled indexing with scale 1, 2, 4 and 8. Such an operand takes one index byte: bits 7:3 give the base mode and bits 2:0 the index register. The parser reports scale, register and base mode for that operand.
- R4: The first byte of a displacement selects its length. A first byte of 0xxxxxxx means 1 byte with a 7-bit value. 10xxxxxx means 2 bytes with a 14-bit value. 11xxxxxx means 4 bytes with a 30-bit value. The value is two's complement and is sign-extended to 32 bits.
- R5: An immediate's length comes from `imm_size`: 00 means 1 byte, 01 means 2 bytes, 10 or 11 means 4 bytes. The bytes arrive MSB first and the value is zero-extended into field 0.
- R6: The effective mode of an operand decides its fields. For an unscaled operand this is its own mode; for a scaled operand it is the base mode from its index byte.
  - Modes 0–7, 19, 23 and 28–31 take no field.
  - Modes 8–15, 21 and 24–27 take one displacement, placed in field 0.
  - Modes 16–18 and 22 take two displacements, placed in fields 0 and 1.
  - Mode 20 takes one immediate.
  - A base mode of 20 or 28–31 behind an index byte takes no field.
- R7: Stream order is: index byte A, index byte B, fields of A, fields of B, then implied displacements.
- R8: `impl_cnt` implied displacements, each coded as in R4, follow the operand fields. A count above NUM_IMPL is treated as NUM_IMPL.
- R9: `out_len` equals `base_len` (1 to 3) plus the number of extension bytes consumed. The parser consumes exactly the bytes the descriptor implies.
- R10: While `out_valid` is 1, `in_ready` is 0 and all result outputs hold steady until `out_ready`. The cycle after acceptance, `out_valid` is 0 again.
- R11: Any field, index register, base mode or scale that the descriptor does not call for reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Descriptor valid pulse, taken when idle |
| mode_a | input | 5 | Addressing mode of operand A |
| mode_b | input | 5 | Addressing mode of operand B |
| imm_size | input | 2 | Immediate length code |
| base_len | input | 2 | Length of the fixed instruction part in bytes |
| impl_cnt | input | $clog2(NUM_IMPL+1) | Number of implied trailing displacements |
| in_valid | input | 1 | Extension byte valid |
| in_data | input | 8 | Extension byte |
| in_ready | output | 1 | Parser takes a byte this cycle |
| out_valid | output | 1 | Results are presented |
| out_ready | input | 1 | Consumer accepts the results |
| out_len | output | LEN_W | Total instruction length in bytes |
| a_field0 | output | 32 | Operand A first displacement or immediate |
| a_field1 | output | 32 | Operand A second displacement |
| b_field0 | output | 32 | Operand B first displacement or immediate |
| b_field1 | output | 32 | Operand B second displacement |
| a_idx_reg | output | 3 | Operand A index register |
| a_idx_mode | output | 5 | Operand A base mode |
| a_scale | output | 4 | Operand A scale factor (0 when unscaled) |
| b_idx_reg | output | 3 | Operand B index register |
| b_idx_mode | output | 5 | Operand B base mode |
| b_scale | output | 4 | Operand B scale factor (0 when unscaled) |
| impl_disp | output | 32*NUM_IMPL | Implied displacements, entry k at bits 32k+31:32k |

## Verification
The bench uses the default NUM_IMPL of 2. This makes `impl_cnt` two bits wide, so a count of 3 can be driven and the clamp to two implied fields is exercised. The longest stream this setting allows is 3+2+16+8 bytes, which puts every length branch of the field assembler within reach. It also puts the deepest slot walk within reach: both operands scaled, each with a two-displacement base mode, followed by both implied fields. Random modes, length prefixes, extreme displacement values, input gaps, output stalls and stray `start` pulses run against a behavioural byte-queue model.

// File: rtl/ext_parser_pkg.sv
package ext_parser_pkg;

    typedef enum logic [1:0] {
        MC_NONE,
        MC_DISP1,
        MC_DISP2,
        MC_IMM
    } mode_cls_e;

    typedef enum logic [1:0] {
        FK_IDX,
        FK_DISP,
        FK_IMM
    } fld_kind_e;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_WALK,
        PS_FIELD,
        PS_DONE
    } pstate_e;

    typedef struct packed {
        logic [2:0] ireg;
        logic [4:0] base;
        logic [3:0] scale;
        mode_cls_e  cls;
    } idx_info_t;

    function automatic logic is_scaled(input logic [4:0] m);
        return m[4:2] == 3'b111;
    endfunction

    // Extension class of a non-scaled addressing mode
    function automatic mode_cls_e classify(input logic [4:0] m);
        mode_cls_e c;
        if (m < 5'd8)                       c = MC_NONE;
        else if (m < 5'd16)                 c = MC_DISP1;
        else if (m <= 5'd18)                c = MC_DISP2;
        else if (m == 5'd20)                c = MC_IMM;
        else if (m == 5'd21)                c = MC_DISP1;
        else if (m == 5'd22)                c = MC_DISP2;
        else if (m >= 5'd24 && m <= 5'd27)  c = MC_DISP1;
        else                                c = MC_NONE;
        return c;
    endfunction

    function automatic logic [2:0] disp_bytes(input logic [7:0] first);
        logic [2:0] n;
        if (!first[7])     n = 3'd1;
        else if (first[6]) n = 3'd4;
        else               n = 3'd2;
        return n;
    endfunction

    function automatic logic [2:0] imm_bytes(input logic [1:0] sz);
        logic [2:0] n;
        case (sz)
            2'b00:   n = 3'd1;
            2'b01:   n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

    function automatic logic [3:0] scale_of(input logic [4:0] m);
        return is_scaled(m) ? (4'd1 << m[1:0]) : 4'd0;
    endfunction

endpackage

// File: rtl/ext_index_dec.sv
module ext_index_dec
    import ext_parser_pkg::*;
(
    input  logic [4:0] op_mode,
    input  logic [7:0] idx_byte,
    output idx_info_t  info
);

    always_comb begin
        info = '{ireg: 3'd0, base: 5'd0, scale: 4'd0, cls: MC_NONE};
        if (is_scaled(op_mode)) begin
            info.ireg  = idx_byte[2:0];
            info.base  = idx_byte[7:3];
            info.scale = scale_of(op_mode);
            // an immediate or a further scaled mode cannot be an index base
            info.cls   = (classify(idx_byte[7:3]) == MC_IMM) ? MC_NONE
                                                             : classify(idx_byte[7:3]);
        end else begin
            info.cls = classify(op_mode);
        end
    end

endmodule

// File: rtl/ext_field_asm.sv
module ext_field_asm
    import ext_parser_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  fld_kind_e   kind,
    input  logic [1:0]  imm_sz,
    input  logic        fire,
    input  logic [7:0]  din,
    output logic        last,
    output logic [31:0] value
);

    logic [2:0]  cnt_q;
    logic [2:0]  need_q;
    logic [23:0] acc_q;
    logic [2:0]  first_need;
    logic [2:0]  need;
    logic [31:0] full;

    always_comb begin
        case (kind)
            FK_IDX:  first_need = 3'd1;
            FK_IMM:  first_need = imm_bytes(imm_sz);
            default: first_need = disp_bytes(din);
        endcase
        need = (cnt_q == 3'd0) ? first_need : need_q;
        last = fire && ((cnt_q + 3'd1) == need);
        full = {acc_q, din};
        case (kind)
            FK_IDX: value = {24'd0, din};
            FK_IMM: value = full;
            default: begin
                case (need)
                    3'd1:    value = {{25{full[6]}}, full[6:0]};
                    3'd2:    value = {{18{full[13]}}, full[13:0]};
                    default: value = {{2{full[29]}}, full[29:0]};
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !active || last) begin
            cnt_q  <= 3'd0;
            need_q <= 3'd0;
            acc_q  <= 24'd0;
        end else if (fire) begin
            cnt_q <= cnt_q + 3'd1;
            acc_q <= full[23:0];
            if (cnt_q == 3'd0) need_q <= first_need;
        end
    end

endmodule

// File: rtl/ext_parser.sv
module ext_parser
    import ext_parser_pkg::*;
#(
    parameter int NUM_IMPL = 2,
    localparam int IC_W    = $clog2(NUM_IMPL + 1),
    localparam int MAX_LEN = 3 + 2 + 16 + 4 * NUM_IMPL,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [4:0]            mode_a,
    input  logic [4:0]            mode_b,
    input  logic [1:0]            imm_size,
    input  logic [1:0]            base_len,
    input  logic [IC_W-1:0]       impl_cnt,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    output logic                  in_ready,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [LEN_W-1:0]      out_len,
    output logic [31:0]           a_field0,
    output logic [31:0]           a_field1,
    output logic [31:0]           b_field0,
    output logic [31:0]           b_field1,
    output logic [2:0]            a_idx_reg,
    output logic [4:0]            a_idx_mode,
    output logic [3:0]            a_scale,
    output logic [2:0]            b_idx_reg,
    output logic [4:0]            b_idx_mode,
    output logic [3:0]            b_scale,
    output logic [32*NUM_IMPL-1:0] impl_disp
);

    // slots: 0,1 index bytes; 2..5 operand fields; 6.. implied fields
    localparam int NSLOT  = 6 + NUM_IMPL;
    localparam int SLOT_W = $clog2(NSLOT + 1);

    pstate_e          state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [4:0]       mode_q [2];
    logic [1:0]       isz_q;
    logic [1:0]       blen_q;
    logic [IC_W-1:0]  icnt_q;
    logic [LEN_W-1:0] nbytes_q;
    logic [7:0]       ix_q  [2];
    logic [31:0]      op_q  [4];
    logic [31:0]      imp_q [NUM_IMPL];

    idx_info_t  ix_info [2];
    logic       slot_need;
    fld_kind_e  slot_kind;
    logic       fire;
    logic       fld_last;
    logic [31:0] fld_val;
    int         impl_eff;

    for (genvar g = 0; g < 2; g++) begin : g_dec
        ext_index_dec u_dec (
            .op_mode  (mode_q[g]),
            .idx_byte (ix_q[g]),
            .info     (ix_info[g])
        );
    end

    assign in_ready  = (state_q == PS_FIELD);
    assign out_valid = (state_q == PS_DONE);
    assign fire      = in_valid && in_ready;

    always_comb begin
        impl_eff  = (int'(icnt_q) > NUM_IMPL) ? NUM_IMPL : int'(icnt_q);
        slot_need = 1'b0;
        slot_kind = FK_DISP;
        case (slot_q)
            SLOT_W'(0): begin slot_need = is_scaled(mode_q[0]); slot_kind = FK_IDX; end
            SLOT_W'(1): begin slot_need = is_scaled(mode_q[1]); slot_kind = FK_IDX; end
            SLOT_W'(2): begin
                slot_need = (ix_info[0].cls != MC_NONE);
                slot_kind = (ix_info[0].cls == MC_IMM) ? FK_IMM : FK_DISP;
            end
            SLOT_W'(3): slot_need = (ix_info[0].cls == MC_DISP2);
            SLOT_W'(4): begin
                slot_need = (ix_info[1].cls != MC_NONE);
                slot_kind = (ix_info[1].cls == MC_IMM) ? FK_IMM : FK_DISP;
            end
            SLOT_W'(5): slot_need = (ix_info[1].cls == MC_DISP2);
            default: slot_need = (int'(slot_q) < NSLOT) && ((int'(slot_q) - 6) < impl_eff);
        endcase
    end

    ext_field_asm u_asm (
        .clk    (clk),
        .rst    (rst),
        .active (state_q == PS_FIELD),
        .kind   (slot_kind),
        .imm_sz (isz_q),
        .fire   (fire),
        .din    (in_data),
        .last   (fld_last),
        .value  (fld_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PS_IDLE;
            slot_q   <= '0;
            mode_q   <= '{5'd0, 5'd0};
            isz_q    <= 2'd0;
            blen_q   <= 2'd0;
            icnt_q   <= '0;
            nbytes_q <= '0;
            ix_q     <= '{8'd0, 8'd0};
            for (int i = 0; i < 4; i++) op_q[i] <= 32'd0;
            for (int i = 0; i < NUM_IMPL; i++) imp_q[i] <= 32'd0;
        end else begin
            case (state_q)
                PS_IDLE: if (start) begin
                    mode_q   <= '{mode_a, mode_b};
                    isz_q    <= imm_size;
                    blen_q   <= base_len;
                    icnt_q   <= impl_cnt;
                    nbytes_q <= '0;
                    slot_q   <= '0;
                    ix_q     <= '{8'd0, 8'd0};
                    for (int i = 0; i < 4; i++) op_q[i] <= 32'd0;
                    for (int i = 0; i < NUM_IMPL; i++) imp_q[i] <= 32'd0;
                    state_q  <= PS_WALK;
                end
                PS_WALK: begin
                    if (int'(slot_q) >= NSLOT) state_q <= PS_DONE;
                    else if (slot_need)        state_q <= PS_FIELD;
                    else                       slot_q  <= slot_q + SLOT_W'(1);
                end
                PS_FIELD: begin
                    if (fire) nbytes_q <= nbytes_q + LEN_W'(1);
                    if (fld_last) begin
                        for (int i = 0; i < 2; i++)
                            if (slot_q == SLOT_W'(i)) ix_q[i] <= fld_val[7:0];
                        for (int i = 0; i < 4; i++)
                            if (slot_q == SLOT_W'(i + 2)) op_q[i] <= fld_val;
                        for (int i = 0; i < NUM_IMPL; i++)
                            if (slot_q == SLOT_W'(i + 6)) imp_q[i] <= fld_val;
                        slot_q  <= slot_q + SLOT_W'(1);
                        state_q <= PS_WALK;
                    end
                end
                default: if (out_ready) state_q <= PS_IDLE;
            endcase
        end
    end

    assign out_len    = LEN_W'(blen_q) + nbytes_q;
    assign a_field0   = op_q[0];
    assign a_field1   = op_q[1];
    assign b_field0   = op_q[2];
    assign b_field1   = op_q[3];
    assign a_idx_reg  = ix_info[0].ireg;
    assign a_idx_mode = ix_info[0].base;
    assign a_scale    = ix_info[0].scale;
    assign b_idx_reg  = ix_info[1].ireg;
    assign b_idx_mode = ix_info[1].base;
    assign b_scale    = ix_info[1].scale;

    for (genvar k = 0; k < NUM_IMPL; k++) begin : g_imp
        assign impl_disp[32*k +: 32] = imp_q[k];
    end

endmodule

// File: rtl/ext_parser_chk.sv
module ext_parser_chk #(
    parameter int NUM_IMPL = 2,
    localparam int MAX_LEN = 3 + 2 + 16 + 4 * NUM_IMPL,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [LEN_W-1:0] out_len,
    input logic [31:0]      a_field0,
    input logic [31:0]      b_field0,
    input logic [3:0]       a_scale,
    input logic [3:0]       b_scale
);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !in_ready)); // R1

    AST_NO_INTAKE_WHILE_PRESENTING: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R10

    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_len)
                                       && $stable(a_field0) && $stable(b_field0))); // R10

    AST_RELEASE_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid); // R10

    AST_LEN_COVERS_INDEX: assert property (@(posedge clk) disable iff (rst)
        (out_valid && a_scale != 4'd0 && b_scale != 4'd0) |-> (out_len >= LEN_W'(3))); // R9

endmodule

bind ext_parser ext_parser_chk #(.NUM_IMPL(NUM_IMPL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_len   (out_len),
    .a_field0  (a_field0),
    .b_field0  (b_field0),
    .a_scale   (a_scale),
    .b_scale   (b_scale)
);

// File: tb/tb_ext_parser.sv
module tb_ext_parser;

    localparam int NUM_IMPL = 2;
    localparam int IC_W     = $clog2(NUM_IMPL + 1);
    localparam int MAX_LEN  = 3 + 2 + 16 + 4 * NUM_IMPL;
    localparam int LEN_W    = $clog2(MAX_LEN + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [4:0] mode_a = '0, mode_b = '0;
    logic [1:0] imm_size = '0, base_len = '0;
    logic [IC_W-1:0] impl_cnt = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, out_valid;
    logic out_ready = 1'b0;
    logic [LEN_W-1:0] out_len;
    logic [31:0] a_field0, a_field1, b_field0, b_field1;
    logic [2:0] a_idx_reg, b_idx_reg;
    logic [4:0] a_idx_mode, b_idx_mode;
    logic [3:0] a_scale, b_scale;
    logic [32*NUM_IMPL-1:0] impl_disp;

    always #5 clk = ~clk;

    ext_parser #(.NUM_IMPL(NUM_IMPL)) dut (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [7:0]  q [$];
    logic [31:0] e_f [4];
    logic [31:0] e_imp [NUM_IMPL];
    logic [2:0]  e_ireg [2];
    logic [4:0]  e_imode [2];
    logic [3:0]  e_scale [2];
    int          e_len;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // per-clock protocol comparison (R10)
    always @(negedge clk) if (!rst && out_valid) chk(!in_ready, "R10 ready low while presenting", 32'(in_ready), 0);

    // extension class by mode: 0 none, 1 one disp, 2 two disps, 3 immediate
    function automatic int mcls(input int m);
        if (m < 8) return 0;
        if (m < 16) return 1;
        if (m <= 18) return 2;
        if (m == 20) return 3;
        if (m == 21) return 1;
        if (m == 22) return 2;
        if (m >= 24 && m <= 27) return 1;
        return 0;
    endfunction

    task automatic push_disp(output logic [31:0] v);
        int l = $urandom % 3;
        int pick = $urandom % 4;
        logic [29:0] r = 30'($urandom);
        if (l == 0) begin
            if (pick == 0) r = 30'h40; else if (pick == 1) r = 30'h3f;
            v = {{25{r[6]}}, r[6:0]};
            q.push_back({1'b0, r[6:0]});
        end else if (l == 1) begin
            if (pick == 0) r = 30'h2000; else if (pick == 1) r = 30'h1fff;
            v = {{18{r[13]}}, r[13:0]};
            q.push_back({2'b10, r[13:8]});
            q.push_back(r[7:0]);
        end else begin
            if (pick == 0) r = 30'h2000_0000; else if (pick == 1) r = 30'h1fff_ffff;
            v = {{2{r[29]}}, r};
            q.push_back({2'b11, r[29:24]});
            q.push_back(r[23:16]);
            q.push_back(r[15:8]);
            q.push_back(r[7:0]);
        end
    endtask

    task automatic push_imm(input int sz, output logic [31:0] v);
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        logic [31:0] r = $urandom;
        v = 0;
        for (int i = n - 1; i >= 0; i--) begin
            q.push_back(r[8*i +: 8]);
            v[8*i +: 8] = r[8*i +: 8];
        end
    endtask

    task automatic build(input int ma, input int mb, input int isz, input int bl, input int ic);
        int m, cl[2], ne;
        q.delete();
        for (int i = 0; i < 4; i++) e_f[i] = 0;
        for (int i = 0; i < NUM_IMPL; i++) e_imp[i] = 0;
        for (int op = 0; op < 2; op++) begin
            m = op ? mb : ma;
            e_ireg[op] = 0; e_imode[op] = 0; e_scale[op] = 0;
            if (m >= 28) begin
                e_imode[op] = 5'($urandom);
                e_ireg[op]  = 3'($urandom);
                e_scale[op] = 4'(1 << (m - 28));
                q.push_back({e_imode[op], e_ireg[op]});
                cl[op] = (mcls(int'(e_imode[op])) == 3) ? 0 : mcls(int'(e_imode[op]));
            end else cl[op] = mcls(m);
        end
        for (int op = 0; op < 2; op++) begin
            if (cl[op] == 3) push_imm(isz, e_f[2*op]);
            if (cl[op] == 1 || cl[op] == 2) push_disp(e_f[2*op]);
            if (cl[op] == 2) push_disp(e_f[2*op+1]);
        end
        ne = (ic > NUM_IMPL) ? NUM_IMPL : ic;
        for (int k = 0; k < ne; k++) push_disp(e_imp[k]);
        e_len = bl + q.size();
    endtask

    task automatic compare_all(input string tag);
        chk(out_len == LEN_W'(e_len), {"R9 length ", tag}, 32'(out_len), 32'(e_len));
        chk(a_field0 == e_f[0], {"R4/R5/R6 a_field0 ", tag}, a_field0, e_f[0]);
        chk(a_field1 == e_f[1], {"R6/R11 a_field1 ", tag}, a_field1, e_f[1]);
        chk(b_field0 == e_f[2], {"R4/R5/R7 b_field0 ", tag}, b_field0, e_f[2]);
        chk(b_field1 == e_f[3], {"R7/R11 b_field1 ", tag}, b_field1, e_f[3]);
        chk({a_scale, a_idx_reg, a_idx_mode} == {e_scale[0], e_ireg[0], e_imode[0]},
            {"R3 index A ", tag}, 32'({a_scale, a_idx_reg, a_idx_mode}), 32'({e_scale[0], e_ireg[0], e_imode[0]}));
        chk({b_scale, b_idx_reg, b_idx_mode} == {e_scale[1], e_ireg[1], e_imode[1]},
            {"R3 index B ", tag}, 32'({b_scale, b_idx_reg, b_idx_mode}), 32'({e_scale[1], e_ireg[1], e_imode[1]}));
        for (int k = 0; k < NUM_IMPL; k++)
            chk(impl_disp[32*k +: 32] == e_imp[k], {"R8 implied ", tag}, impl_disp[32*k +: 32], e_imp[k]);
    endtask

    task automatic run_txn(input int ma, input int mb, input int isz, input int bl,
                           input int ic, input bit poke, input string tag);
        int guard = 0;
        bit poked = 0;
        build(ma, mb, isz, bl, ic);
        @(negedge clk);
        start = 1; mode_a = 5'(ma); mode_b = 5'(mb); imm_size = 2'(isz);
        base_len = 2'(bl); impl_cnt = IC_W'(ic);
        @(negedge clk);
        start = 0; mode_a = 5'($urandom); mode_b = 5'($urandom);
        imm_size = 2'($urandom); base_len = 2'($urandom); impl_cnt = IC_W'($urandom);
        while (!out_valid && guard < 400) begin
            guard++;
            if (poke && !poked && guard == 3) begin start = 1; poked = 1; end // R2
            else start = 0;
            in_valid = (q.size() > 0) && ($urandom % 4 != 0);
            in_data  = in_valid ? q[0] : 8'($urandom);
            #1;
            if (in_valid && in_ready) void'(q.pop_front());
            @(negedge clk);
            start = 0;
        end
        in_valid = 0;
        chk(out_valid && q.size() == 0, {"R9 exact byte count ", tag}, 32'(q.size()), 0);
        compare_all(tag);
        // stall the consumer and look again (R10)
        repeat (2) @(negedge clk);
        chk(out_valid, {"R10 still presenting ", tag}, 32'(out_valid), 1);
        compare_all({tag, " held"});
        if (poke) begin
            start = 1; // R2: start while presenting is ignored
            @(negedge clk);
            start = 0;
            compare_all({tag, " start-ignored"});
        end
        out_ready = 1;
        @(negedge clk);
        out_ready = 0;
        chk(!out_valid && !in_ready, {"R10 idle after accept ", tag}, 32'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!in_ready && !out_valid, "R1 reset state", 32'({in_ready, out_valid}), 0);
        run_txn(3, 5, 0, 1, 0, 0, "no-extension");
        run_txn(20, 20, 0, 2, 0, 0, "imm 1B");
        run_txn(20, 10, 1, 3, 0, 0, "imm 2B");
        run_txn(7, 20, 2, 1, 0, 0, "imm 4B");
        run_txn(20, 20, 3, 1, 0, 0, "imm code3");
        run_txn(16, 22, 0, 2, 0, 0, "two disps each");
        run_txn(28, 31, 0, 1, 0, 0, "scaled pair");
        run_txn(29, 30, 2, 3, 2, 0, "scaled+implied");
        run_txn(0, 0, 0, 1, 3, 0, "implied clamp R8");
        run_txn(12, 21, 0, 2, 1, 1, "start ignored R2");
        for (int t = 0; t < 400; t++)
            run_txn($urandom % 32, $urandom % 32, $urandom % 4, 1 + $urandom % 3,
                    $urandom % 4, ($urandom % 5 == 0), "random");
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!in_ready && !out_valid, "R1 reset again", 32'({in_ready, out_valid}), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule